// File: doc/BRIEF.md
# Operand Address Mode Resolver

This block supplies the data operand for a load-type instruction on an 8-bit accumulator machine. Each request carries the second byte of a two-byte instruction, a two-bit operand mode code and the current value of the X index register. The block returns the operand in one of three ways. In immediate mode the byte itself is the operand. In direct mode the byte is a one-byte data RAM address. In indexed mode the address is the byte used as a base plus X.

Memory is a synchronous 256x8 data RAM that sits outside the block. It answers a read one clock after the request. The block drives the read strobe and the address, then passes the returned byte out with a valid strobe. An immediate operand comes back in the same cycle as its request, and a memory operand comes back one cycle later. While a read is outstanding the block raises `busy` and drops new requests. The mode code 11 is not a legal mode: it flags an error and makes no memory access.

Top module: `opnd_resolver`

## Requirements
- R1: Mode code 00 (immediate) in an accepted request drives `opnd_valid`=1 with `opnd_data` equal to `req_byte` in that same cycle, and `mem_rd_en` stays 0.
- R2: Mode code 01 (direct) in an accepted request drives `mem_rd_en`=1 with `mem_addr` equal to `req_byte` in the request cycle. In the next cycle `opnd_valid`=1 and `opnd_data` equals the byte the RAM returns from that address.
- R3: Mode code 10 (indexed) drives `mem_rd_en`=1 with `mem_addr` = (`req_byte` + `x_reg`) mod 256, with no carry out. For example, 0x10+0x03 gives 0x13 and 0xFE+0x05 gives 0x03. The operand comes back one cycle later, as in R2.
- R4: Mode code 11 in an accepted request drives `mode_err`=1 in the request cycle, with `mem_rd_en`=0 and `opnd_valid`=0.
- R5: `busy` is 1 for exactly the one cycle after a request that started a memory read. A request offered while `busy`=1 is dropped: it causes no `mem_rd_en`, no `mode_err` and no immediate result.
- R6: While `rst_n` is low and after it is released, `busy` and `opnd_valid` are 0 until a request arrives.
- R7: With `req_valid`=0 and no read outstanding, `mem_rd_en`, `opnd_valid` and `mode_err` are all 0.
- R8: In direct mode `x_reg` does not affect `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operand request strobe |
| req_mode | input | 2 | Mode code: 00 immediate, 01 direct, 10 indexed, 11 illegal |
| req_byte | input | BYTE_W | Second instruction byte (constant, address or base) |
| x_reg | input | BYTE_W | X index register value |
| busy | output | 1 | A memory read is outstanding and requests are dropped |
| mem_rd_en | output | 1 | Read strobe to the data RAM |
| mem_addr | output | BYTE_W | Read address to the data RAM |
| mem_rd_data | input | DATA_W | RAM read data, one cycle after `mem_rd_en` |
| opnd_valid | output | 1 | Operand valid strobe |
| opnd_data | output | DATA_W | Resolved operand |
| mode_err | output | 1 | Illegal mode code seen in an accepted request |

## Verification
The bench targets the indexed addresses whose sum passes 0xFF. A design that kept or misplaced the carry would read the wrong RAM cell, so the returned data would not match. It also sends requests in the cycle right after a memory request. A design that accepted them would issue a second read or an error strobe, or show an immediate result in place of the returned byte. The bench also varies X during direct requests and sends the illegal code 11. These catch any leak of X into the direct address and any memory access or valid strobe on an illegal mode.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

   typedef enum logic [1:0] {
      MODE_IMM = 2'b00,
      MODE_DIR = 2'b01,
      MODE_IDX = 2'b10,
      MODE_BAD = 2'b11
   } opnd_mode_e;

   typedef struct packed {
      logic take_imm;
      logic take_dir;
      logic take_idx;
      logic take_bad;
   } opnd_sel_t;

endpackage

// File: rtl/opnd_mode_dec.sv
module opnd_mode_dec
   import opnd_pkg::*;
(
   input  logic       req_valid,
   input  logic       blocked,
   input  logic [1:0] req_mode,
   output opnd_sel_t  sel
);

   logic       accept;
   opnd_mode_e mode;

   assign accept = req_valid & ~blocked;
   assign mode   = opnd_mode_e'(req_mode);

   always_comb begin
      sel = '0;
      if (accept) begin
         unique case (mode)
            MODE_IMM: sel.take_imm = 1'b1;
            MODE_DIR: sel.take_dir = 1'b1;
            MODE_IDX: sel.take_idx = 1'b1;
            MODE_BAD: sel.take_bad = 1'b1;
         endcase
      end
   end

   // R4
   always_comb begin
      if (sel.take_bad) onehot_sel_chk: assert ($onehot(sel));
   end

endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen #(
   parameter int AW           = 8,
   parameter bit RIPPLE_ADDER = 1'b1
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] index,
   input  logic          use_index,
   output logic [AW-1:0] addr
);

   if (AW < 2) begin : g_bad_aw
      $error("opnd_addr_gen: AW must be at least 2");
   end

   logic [AW-1:0] addend;
   assign addend = use_index ? index : '0;

   if (RIPPLE_ADDER) begin : g_ripple
      logic [AW-1:0] carry;
      assign carry[0] = 1'b0;
      for (genvar i = 0; i < AW; i++) begin : g_bit
         logic half;
         assign half    = base[i] ^ addend[i];
         assign addr[i] = half ^ carry[i];
         if (i < AW - 1) begin : g_cy
            assign carry[i+1] = (base[i] & addend[i]) | (carry[i] & half);
         end
      end
   end else begin : g_behav
      assign addr = base + addend;
   end

endmodule

// File: rtl/opnd_rd_track.sv
module opnd_rd_track (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_start,
   output logic pend
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= rd_start;
   end

   // R5
   busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend |=> !pend);

endmodule

// File: rtl/opnd_result_mux.sv
module opnd_result_mux #(
   parameter int BW = 8,
   parameter int DW = 8
) (
   input  logic          imm_hit,
   input  logic [BW-1:0] imm_byte,
   input  logic          rd_pend,
   input  logic [DW-1:0] rd_data,
   output logic          valid,
   output logic [DW-1:0] data
);

   logic [DW-1:0] imm_ext;

   if (DW >= BW) begin : g_zext
      assign imm_ext = DW'(imm_byte);
   end else begin : g_trunc
      assign imm_ext = imm_byte[DW-1:0];
   end

   assign valid = imm_hit | rd_pend;
   assign data  = rd_pend ? rd_data : imm_ext;

   // R5
   always_comb begin
      if (rd_pend) no_imm_in_busy_chk: assert (!imm_hit);
   end

endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
   import opnd_pkg::*;
#(
   parameter int BYTE_W       = 8,
   parameter int DATA_W       = 8,
   parameter bit RIPPLE_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_mode,
   input  logic [BYTE_W-1:0] req_byte,
   input  logic [BYTE_W-1:0] x_reg,
   output logic              busy,
   output logic              mem_rd_en,
   output logic [BYTE_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              opnd_valid,
   output logic [DATA_W-1:0] opnd_data,
   output logic              mode_err
);

   localparam int MEM_DEPTH = 1 << BYTE_W;

   if (BYTE_W < 2 || BYTE_W > 16) begin : g_bad_bw
      $error("opnd_resolver: BYTE_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("opnd_resolver: DATA_W must be positive");
   end
   if (MEM_DEPTH < 4) begin : g_bad_depth
      $error("opnd_resolver: memory too small");
   end

   opnd_sel_t sel;
   logic      pend;

   opnd_mode_dec u_dec (
      .req_valid (req_valid),
      .blocked   (pend),
      .req_mode  (req_mode),
      .sel       (sel)
   );

   opnd_addr_gen #(.AW(BYTE_W), .RIPPLE_ADDER(RIPPLE_ADDER)) u_agen (
      .base      (req_byte),
      .index     (x_reg),
      .use_index (sel.take_idx),
      .addr      (mem_addr)
   );

   assign mem_rd_en = sel.take_dir | sel.take_idx;
   assign mode_err  = sel.take_bad;
   assign busy      = pend;

   opnd_rd_track u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_start (mem_rd_en),
      .pend     (pend)
   );

   opnd_result_mux #(.BW(BYTE_W), .DW(DATA_W)) u_mux (
      .imm_hit  (sel.take_imm),
      .imm_byte (req_byte),
      .rd_pend  (pend),
      .rd_data  (mem_rd_data),
      .valid    (opnd_valid),
      .data     (opnd_data)
   );

   // R1
   imm_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_mode == 2'b00) |->
         (opnd_valid && !mem_rd_en && opnd_data == DATA_W'(req_byte)));

   // R2
   rd_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> (opnd_valid && busy));

   // R8
   dir_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_mode == 2'b01) |-> (mem_rd_en && mem_addr == req_byte));

   // R3
   idx_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_mode == 2'b10) |->
         (mem_rd_en && mem_addr == BYTE_W'(req_byte + x_reg)));

   // R4
   bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> (!mem_rd_en && !opnd_valid));

   // R5
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!mem_rd_en && !mode_err));

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && !busy) |-> (!mem_rd_en && !opnd_valid && !mode_err));

endmodule

// File: tb/opnd_resolver_tb.sv
module opnd_resolver_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int BW = 8;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_mode = 2'b00;
   logic [BW-1:0] req_byte = '0;
   logic [BW-1:0] x_reg = '0;
   logic          busy, mem_rd_en, opnd_valid, mode_err;
   logic [BW-1:0] mem_addr;
   logic [DW-1:0] mem_rd_data;
   logic [DW-1:0] opnd_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   opnd_resolver #(.BYTE_W(BW), .DATA_W(DW)) dut_i (
      .clk, .rst_n, .req_valid, .req_mode, .req_byte, .x_reg,
      .busy, .mem_rd_en, .mem_addr, .mem_rd_data,
      .opnd_valid, .opnd_data, .mode_err
   );

   // behavioural RAM, one-cycle read latency
   logic [DW-1:0] ram [256];
   initial begin
      for (int i = 0; i < 256; i++) ram[i] = DW'(((i * 7 + 3) ^ 8'h5A) & 8'hFF);
   end
   always @(posedge clk) if (mem_rd_en) mem_rd_data <= ram[mem_addr];

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 0;

   // reference model state
   bit       m_pend = 0;
   int       m_data = 0;

   task automatic chk(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(bit v, int mode, int b, int x);
      bit acc, e_rd, e_err, e_vld;
      int e_addr, e_dat;
      string rq;
      @(negedge clk);
      req_valid = v; req_mode = 2'(mode); req_byte = BW'(b); x_reg = BW'(x);
      #2;
      acc    = v && !m_pend;
      e_rd   = acc && (mode == 1 || mode == 2);
      e_err  = acc && mode == 3;
      e_vld  = m_pend || (acc && mode == 0);
      e_addr = (mode == 2) ? ((b + x) % 256) : b;
      e_dat  = m_pend ? m_data : b;
      rq = (mode == 0) ? "R1" : (mode == 1) ? "R2" : (mode == 2) ? "R3" : "R4";
      chk("R5", "busy", int'(busy), int'(m_pend));
      chk(v ? rq : "R7", "mem_rd_en", int'(mem_rd_en), int'(e_rd));
      chk(v ? "R4" : "R7", "mode_err", int'(mode_err), int'(e_err));
      chk(m_pend ? "R2" : rq, "opnd_valid", int'(opnd_valid), int'(e_vld));
      if (e_rd) chk(mode == 1 ? "R8" : "R3", "mem_addr", int'(mem_addr), e_addr);
      if (e_vld) chk(m_pend ? "R2" : "R1", "opnd_data", int'(opnd_data), e_dat);
      @(posedge clk);
      if (e_rd) m_data = int'(ram[e_addr]);
      m_pend = e_rd;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected<=100000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R6: reset state
      repeat (3) begin
         @(negedge clk); #2;
         chk("R6", "busy", int'(busy), 0);
         chk("R6", "opnd_valid", int'(opnd_valid), 0);
      end
      @(negedge clk); rst_n = 1'b1;
      step(0, 0, 0, 0);                 // R7 idle
      step(1, 0, 8'hA5, 8'h33);         // R1 immediate
      step(1, 1, 8'h40, 8'h77);         // R2/R8 direct, X ignored
      step(0, 0, 0, 0);                 // read returns
      step(1, 2, 8'h10, 8'h03);         // R3 0x13
      step(1, 0, 8'h99, 0);             // R5 dropped while busy
      step(1, 2, 8'hFE, 8'h05);         // R3 wrap to 0x03
      step(1, 3, 8'h12, 0);             // R5 bad mode during busy: dropped
      step(1, 3, 8'h12, 8'h01);         // R4 illegal mode
      step(1, 1, 8'hFF, 8'hFF);         // R2 top cell
      step(1, 2, 8'h80, 8'h80);         // R5 dropped
      step(1, 2, 8'h80, 8'h80);         // R3 wrap to 0x00
      step(1, 1, 8'h00, 0);
      for (int k = 0; k < 600; k++)
         step(($urandom % 5) != 0, int'($urandom % 4), int'($urandom % 256), int'($urandom % 256));
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule